// File: doc/BRIEF.md
# Out-of-Order Issue Station Bank

This block holds dispatched instructions that must wait for source operands before they can execute. Each of its entries keeps an opcode and two operand slots. Each operand slot carries either a value or the tag of the instruction that will produce it. All entries watch one shared result bus. A pending operand whose tag appears on that bus takes the broadcast value into its slot.

Once both operands of an entry hold values, the entry may go to the single execution unit. This can happen ahead of older entries that are still waiting. Among ready entries the oldest goes first. An entry leaves only when the execution unit signals that it can take the instruction.

Each entry is a small state machine with three states:
- `SLOT_IDLE`: the entry is free.
- `SLOT_WAIT`: the entry holds an instruction that lacks at least one operand.
- `SLOT_READY`: the entry holds both operands and is eligible to issue.

The transitions are:
- *load*: `SLOT_IDLE` goes to `SLOT_WAIT`, or straight to `SLOT_READY` if both operands are present, counting a capture in the same cycle.
- *capture*: `SLOT_WAIT` goes to `SLOT_READY` when the last missing operand arrives.
- *issue*: `SLOT_READY` goes to `SLOT_IDLE` when the entry is granted and the unit is ready.

Each entry also carries an age value that orders busy entries from oldest to youngest.

Top module: `rsv_bank`

## Requirements
- R1: After reset all four entries are free, `disp_accept` is 1 and `iss_valid` is 0.
- R2: `disp_accept` is 1 whenever at least one of the four entries is free. A dispatch presented while `disp_accept` is 0 is ignored and never issues.
- R3: A pending operand (ready flag 0) whose tag equals `res_tag` in a cycle with `res_valid` 1 takes `res_val`. A broadcast with a different tag leaves it pending.
- R4: A dispatched operand that is pending, and whose tag matches a result broadcast in the same cycle as the dispatch, takes that result's value.
- R5: An entry whose two operands are both present may issue while older entries are still waiting for operands.
- R6: When several entries are ready, `iss_*` presents the one dispatched earliest.
- R7: An instruction leaves only in a cycle with `iss_valid` and `iss_ready` both 1. While `iss_ready` is 0, `iss_valid` stays 1.
- R8: An entry that issues is free from the next cycle, so a full bank shows `disp_accept` 1 after an issue.
- R9: An operand dispatched with ready flag 1 keeps its value, even when a later broadcast carries the same tag as its tag field.
- R10: An entry becomes eligible for issue in the cycle after its last operand arrives. The issued operands are the dispatched or captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 6 | Opcode of dispatched instruction |
| disp_a_rdy | input | 1 | Operand A holds a value (1) or waits on a tag (0) |
| disp_a_tag | input | 4 | Producer tag of operand A |
| disp_a_val | input | 32 | Value of operand A |
| disp_b_rdy | input | 1 | Operand B holds a value (1) or waits on a tag (0) |
| disp_b_tag | input | 4 | Producer tag of operand B |
| disp_b_val | input | 32 | Value of operand B |
| disp_accept | output | 1 | A free entry exists; dispatch taken this cycle |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | 4 | Tag of broadcast result |
| res_val | input | 32 | Broadcast result value |
| iss_valid | output | 1 | A ready instruction is presented |
| iss_ready | input | 1 | Execution unit accepts the presented instruction |
| iss_op | output | 6 | Opcode of presented instruction |
| iss_a | output | 32 | Operand A value of presented instruction |
| iss_b | output | 32 | Operand B value of presented instruction |

## Verification
On every cycle the assertions check a set of invariants:
- `iss_valid` holds while the unit stalls.
- An issue frees room for dispatch.
- A full bank stays full until something issues.
- The grant vector is at most one-hot and agrees with `iss_valid`.

Which instruction issues, with which captured operand values, and in what order relative to older waiting entries can only be shown by the bench. It compares every cycle against its own model, both in directed scenarios and in random mixes of dispatches, broadcasts and stalls. That covers same-cycle capture, ignored dispatches to a full bank, and stale tags on ready operands.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    localparam int TAGW = 4;
    localparam int DATW = 32;
    localparam int OPW  = 6;

    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_WAIT,
        SLOT_READY
    } slot_st_e;

    typedef struct packed {
        logic            rdy;
        logic [TAGW-1:0] tag;
        logic [DATW-1:0] val;
    } opnd_t;

    // Take a broadcast result into a pending operand whose tag matches
    function automatic opnd_t snoop(input opnd_t o, input logic rv,
                                    input logic [TAGW-1:0] rt,
                                    input logic [DATW-1:0] rd);
        opnd_t r;
        r = o;
        if (!o.rdy && rv && (o.tag == rt)) begin
            r.rdy = 1'b1;
            r.val = rd;
        end
        return r;
    endfunction
endpackage

// File: rtl/rsv_slot.sv
module rsv_slot
    import rsv_pkg::*;
#(
    parameter int AGEW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [OPW-1:0]       ld_op,
    input  opnd_t                ld_a,
    input  opnd_t                ld_b,
    input  logic                 res_valid,
    input  logic [TAGW-1:0]      res_tag,
    input  logic [DATW-1:0]      res_val,
    input  logic                 bump,
    input  logic                 drop_v,
    input  logic [AGEW-1:0]      drop_age,
    input  logic                 go,
    output logic                 busy,
    output logic                 ready,
    output logic [AGEW-1:0]      age,
    output logic [OPW-1:0]       op,
    output logic [DATW-1:0]      a_val,
    output logic [DATW-1:0]      b_val
);
    slot_st_e        st_q, st_n;
    opnd_t           a_q, b_q, a_n, b_n;
    logic [OPW-1:0]  op_q, op_n;
    logic [AGEW-1:0] age_q, age_n;

    // next state and data
    always_comb begin
        st_n  = st_q;
        op_n  = op_q;
        a_n   = snoop(a_q, res_valid, res_tag, res_val);
        b_n   = snoop(b_q, res_valid, res_tag, res_val);
        age_n = age_q;
        unique case (st_q)
            SLOT_IDLE: begin
                if (load) begin
                    op_n  = ld_op;
                    a_n   = snoop(ld_a, res_valid, res_tag, res_val);
                    b_n   = snoop(ld_b, res_valid, res_tag, res_val);
                    age_n = '0;
                    st_n  = (a_n.rdy && b_n.rdy) ? SLOT_READY : SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                if (a_n.rdy && b_n.rdy) st_n = SLOT_READY;
            end
            SLOT_READY: begin
                if (go) st_n = SLOT_IDLE;
            end
            default: st_n = SLOT_IDLE;
        endcase
        if (st_q != SLOT_IDLE) begin
            age_n = age_q + AGEW'(bump)
                  - AGEW'(drop_v && (drop_age < age_q));
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SLOT_IDLE;
            op_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            age_q <= '0;
        end else begin
            st_q  <= st_n;
            op_q  <= op_n;
            a_q   <= a_n;
            b_q   <= b_n;
            age_q <= age_n;
        end
    end

    // outputs
    always_comb begin
        busy  = (st_q != SLOT_IDLE);
        ready = (st_q == SLOT_READY);
        age   = age_q;
        op    = op_q;
        a_val = a_q.val;
        b_val = b_q.val;
    end
endmodule

// File: rtl/rsv_alloc.sv
module rsv_alloc #(
    parameter int NSLOT = 4
) (
    input  logic [NSLOT-1:0] busy,
    output logic [NSLOT-1:0] free_oh,
    output logic             any_free
);
    always_comb begin
        free_oh  = '0;
        any_free = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (!busy[i] && !any_free) begin
                free_oh[i] = 1'b1;
                any_free   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsv_pick.sv
module rsv_pick #(
    parameter int NSLOT = 4,
    parameter int AGEW  = 2,
    parameter int IDXW  = 2
) (
    input  logic [NSLOT-1:0]           ready,
    input  logic [NSLOT-1:0][AGEW-1:0] ages,
    output logic [NSLOT-1:0]           grant,
    output logic [IDXW-1:0]            idx,
    output logic                       any
);
    logic [AGEW-1:0] best_age;

    always_comb begin
        any      = 1'b0;
        idx      = '0;
        best_age = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (ready[i] && (!any || ages[i] > best_age)) begin
                any      = 1'b1;
                idx      = IDXW'(i);
                best_age = ages[i];
            end
        end
        grant = '0;
        if (any) grant[idx] = 1'b1;
    end
endmodule

// File: rtl/rsv_bank.sv
module rsv_bank
    import rsv_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [OPW-1:0]  disp_op,
    input  logic            disp_a_rdy,
    input  logic [TAGW-1:0] disp_a_tag,
    input  logic [DATW-1:0] disp_a_val,
    input  logic            disp_b_rdy,
    input  logic [TAGW-1:0] disp_b_tag,
    input  logic [DATW-1:0] disp_b_val,
    output logic            disp_accept,
    input  logic            res_valid,
    input  logic [TAGW-1:0] res_tag,
    input  logic [DATW-1:0] res_val,
    output logic            iss_valid,
    input  logic            iss_ready,
    output logic [OPW-1:0]  iss_op,
    output logic [DATW-1:0] iss_a,
    output logic [DATW-1:0] iss_b
);
    localparam int AGEW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int IDXW = AGEW;

    logic [NSLOT-1:0]           busy, ready, free_oh, sel_oh;
    logic [NSLOT-1:0][AGEW-1:0] ages;
    logic [NSLOT-1:0][OPW-1:0]  ops;
    logic [NSLOT-1:0][DATW-1:0] avals, bvals;
    logic                       any_free, take, fire;
    logic [IDXW-1:0]            sel_idx;
    opnd_t                      ld_a, ld_b;

    assign ld_a = '{rdy: disp_a_rdy, tag: disp_a_tag, val: disp_a_val};
    assign ld_b = '{rdy: disp_b_rdy, tag: disp_b_tag, val: disp_b_val};
    assign take = disp_valid && any_free;
    assign fire = iss_valid && iss_ready;

    rsv_alloc #(.NSLOT(NSLOT)) u_alloc (
        .busy    (busy),
        .free_oh (free_oh),
        .any_free(any_free)
    );

    rsv_pick #(.NSLOT(NSLOT), .AGEW(AGEW), .IDXW(IDXW)) u_pick (
        .ready(ready),
        .ages (ages),
        .grant(sel_oh),
        .idx  (sel_idx),
        .any  (iss_valid)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        rsv_slot #(.AGEW(AGEW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (take && free_oh[g]),
            .ld_op    (disp_op),
            .ld_a     (ld_a),
            .ld_b     (ld_b),
            .res_valid(res_valid),
            .res_tag  (res_tag),
            .res_val  (res_val),
            .bump     (take),
            .drop_v   (fire),
            .drop_age (ages[sel_idx]),
            .go       (iss_ready && sel_oh[g]),
            .busy     (busy[g]),
            .ready    (ready[g]),
            .age      (ages[g]),
            .op       (ops[g]),
            .a_val    (avals[g]),
            .b_val    (bvals[g])
        );
    end

    assign disp_accept = any_free;
    assign iss_op      = ops[sel_idx];
    assign iss_a       = avals[sel_idx];
    assign iss_b       = bvals[sel_idx];
endmodule

// File: rtl/rsv_bank_chk.sv
module rsv_bank_chk #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_accept,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [NSLOT-1:0] grant
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (disp_accept && !iss_valid));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> iss_valid);

    // R8
    free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> disp_accept);

    // R2
    full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_accept && !(iss_valid && iss_ready)) |=> !disp_accept);

    // R6
    grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (iss_valid == (grant != '0)));
endmodule

bind rsv_bank rsv_bank_chk #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_accept(disp_accept),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .grant      (sel_oh)
);

// File: tb/rsv_bank_tb.sv
module rsv_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 0, disp_a_rdy = 0, disp_b_rdy = 0;
    logic [5:0]  disp_op = '0;
    logic [3:0]  disp_a_tag = '0, disp_b_tag = '0, res_tag = '0;
    logic [31:0] disp_a_val = '0, disp_b_val = '0, res_val = '0;
    logic        res_valid = 0, iss_ready = 0;
    logic        disp_accept, iss_valid;
    logic [5:0]  iss_op;
    logic [31:0] iss_a, iss_b;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rsv_bank u_dut (.*);

    // bench model of the four entries
    logic        m_busy [4];
    int          m_seq  [4];
    logic [5:0]  m_op   [4];
    logic        m_ar [4], m_br [4];
    logic [3:0]  m_at [4], m_bt [4];
    logic [31:0] m_av [4], m_bv [4];
    int          seq_ctr = 0;

    function automatic int exp_pick();
        int p = -1;
        for (int i = 0; i < 4; i++)
            if (m_busy[i] && m_ar[i] && m_br[i] && (p < 0 || m_seq[i] < m_seq[p]))
                p = i;
        return p;
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < 4; i++) if (m_busy[i]) c++;
        return c;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_busy[i] = 0;
    endtask

    task automatic model_edge();
        int p = exp_pick();
        int c = m_count();
        int j = -1;
        for (int i = 0; i < 4; i++) if (!m_busy[i] && j < 0) j = i;
        for (int i = 0; i < 4; i++) if (m_busy[i] && res_valid) begin
            if (!m_ar[i] && m_at[i] == res_tag) begin m_ar[i] = 1; m_av[i] = res_val; end
            if (!m_br[i] && m_bt[i] == res_tag) begin m_br[i] = 1; m_bv[i] = res_val; end
        end
        if (p >= 0 && iss_ready) m_busy[p] = 0;
        if (disp_valid && c < 4) begin
            m_busy[j] = 1; m_seq[j] = seq_ctr++; m_op[j] = disp_op;
            m_ar[j] = disp_a_rdy; m_at[j] = disp_a_tag; m_av[j] = disp_a_val;
            m_br[j] = disp_b_rdy; m_bt[j] = disp_b_tag; m_bv[j] = disp_b_val;
            if (res_valid && !m_ar[j] && m_at[j] == res_tag) begin m_ar[j] = 1; m_av[j] = res_val; end
            if (res_valid && !m_br[j] && m_bt[j] == res_tag) begin m_br[j] = 1; m_bv[j] = res_val; end
        end
    endtask

    task automatic cmp(string lbl, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
        end
    endtask

    task automatic compare(string lbl);
        int p = exp_pick();
        cmp(lbl, "disp_accept", 32'(disp_accept), 32'(m_count() < 4));
        cmp(lbl, "iss_valid", 32'(iss_valid), 32'(p >= 0));
        if (p >= 0) begin
            cmp(lbl, "iss_op", 32'(iss_op), 32'(m_op[p]));
            cmp(lbl, "iss_a", iss_a, m_av[p]);
            cmp(lbl, "iss_b", iss_b, m_bv[p]);
        end
    endtask

    // inputs already set at negedge; advance one cycle and compare
    task automatic tick(string lbl);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(lbl);
    endtask

    task automatic set_disp(logic v, logic [5:0] op, logic ar, logic [3:0] at,
                            logic [31:0] av, logic br, logic [3:0] bt, logic [31:0] bv);
        disp_valid = v; disp_op = op;
        disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
        disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
    endtask

    task automatic set_res(logic v, logic [3:0] t, logic [31:0] d);
        res_valid = v; res_tag = t; res_val = d;
    endtask

    task automatic quiet();
        set_disp(0, '0, 0, '0, '0, 0, '0, '0);
        set_res(0, '0, '0);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd418);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        tick("R1");

        // R2 / R8: fill with waiting entries, stall, then try a fifth
        iss_ready = 0;
        set_disp(1, 6'd1, 0, 4'd1, '0, 1, 4'd9, 32'h11); tick("R2");
        set_disp(1, 6'd2, 0, 4'd1, '0, 1, 4'd1, 32'h22); tick("R2");
        set_disp(1, 6'd3, 0, 4'd1, '0, 1, 4'd9, 32'h33); tick("R2");
        set_disp(1, 6'd4, 0, 4'd1, '0, 1, 4'd9, 32'h44); tick("R2");
        set_disp(1, 6'd5, 1, 4'd0, 32'h55, 1, 4'd0, 32'h66); tick("R2");
        quiet();
        // R3: mismatched tag leaves all waiting
        set_res(1, 4'd2, 32'hBAD); tick("R3");
        // R3 / R9: matching tag completes all; entry 2's ready b keeps 22
        set_res(1, 4'd1, 32'hA1); tick("R9");
        quiet(); tick("R10");
        // R7: stall holds
        tick("R7"); tick("R7");
        // R6 / R8: drain oldest first
        iss_ready = 1;
        tick("R8"); tick("R6"); tick("R6"); tick("R6"); tick("R6");

        // R4: dispatch and matching broadcast together
        set_disp(1, 6'd7, 0, 4'd5, '0, 1, 4'd0, 32'h77);
        set_res(1, 4'd5, 32'hC5);
        iss_ready = 0;
        tick("R4"); quiet(); tick("R4");
        iss_ready = 1; tick("R4");

        // R5: old entry waits, younger ready one bypasses it
        iss_ready = 0;
        set_disp(1, 6'd8, 0, 4'd7, '0, 1, 4'd0, 32'h1); tick("R5");
        set_disp(1, 6'd9, 1, 4'd0, 32'h2, 1, 4'd0, 32'h3); tick("R5");
        quiet(); iss_ready = 1; tick("R5"); tick("R5");
        set_res(1, 4'd7, 32'h70); tick("R5"); quiet(); tick("R5"); tick("R5");

        // random mix: R3 R6 R7 R10
        for (int n = 0; n < 4000; n++) begin
            set_disp($urandom_range(1, 0) == 1, 6'($urandom), $urandom_range(1, 0) == 1,
                     4'($urandom_range(7, 0)), $urandom,
                     $urandom_range(1, 0) == 1, 4'($urandom_range(7, 0)), $urandom);
            set_res($urandom_range(1, 0) == 1, 4'($urandom_range(7, 0)), $urandom);
            iss_ready = $urandom_range(3, 0) != 0;
            tick("R6");
        end
        quiet();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule